// File: doc/BRIEF.md
# Period-Controlled Sampling Oscillator

This block is the digitally controlled oscillator of a non-uniform-sampling phase-locked loop. It produces a one-cycle sample strobe whose spacing is set anew on every sample: the next interval equals a nominal period minus a signed correction word supplied by the loop filter. The correction is captured at the instant the strobe fires, so the loop filter may update its output at any time without disturbing an interval that is already running.

A fast mode lets the loop filter converge sooner. An inner oscillator then runs at two or four times the nominal rate by dividing the corrected period by that ratio. Every inner expiry produces a filter tick that clocks the loop filter and captures a fresh correction. A divider passes only every second or fourth inner tick through as the sample strobe, so the outer sampling rate stays nominal. In normal mode the filter tick and the sample strobe are the same pulse. The mode inputs take effect only at a sample strobe.

Top module: `sampling_dco`

## Requirements
- R1: While reset is high, and in the cycle after it, neither output is asserted. Reset loads the counter with the nominal period (with the correction taken as zero) and selects normal mode. The first strobe appears in the cycle after the (T0-1)-th rising edge with reset low.
- R2: In normal mode the number of clock cycles from one strobe to the next equals T0 - c. Here T0 is `nominal_period` (unsigned, 16 bits), c is `correction` (two's complement, 16 bits), and c is the value present in the cycle of the earlier strobe.
- R3: With c = 0 the strobe spacing equals T0 exactly, interval after interval.
- R4: The loaded period saturates: a difference below 2 loads 2, and a difference above 65535 loads 65535.
- R5: A change of `correction` in the middle of an interval does not alter that interval. The new value governs the interval that starts at the next capture.
- R6: With `fast_mode` = 1 and `ratio_sel` = 0 (ratio 2), each inner interval is max(2, P >> 1). P is the saturated period from the correction captured at the previous filter tick. `filter_tick` pulses at every inner expiry, and `sample_strobe` pulses on every 2nd tick.
- R7: With `fast_mode` = 1 and `ratio_sel` = 1 (ratio 4), each inner interval is max(2, P >> 2), and `sample_strobe` pulses on every 4th filter tick.
- R8: In normal mode `filter_tick` equals `sample_strobe` in every cycle, and every strobe coincides with a filter tick.
- R9: `fast_mode` and `ratio_sel` are captured only in a strobe cycle. A change between strobes affects neither the running interval nor its tick count.
- R10: `sample_strobe` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nominal_period | input | 16 | Nominal period T0 in clock cycles |
| correction | input | 16 | Signed loop-filter correction c |
| fast_mode | input | 1 | 1 selects the boosted inner oscillator |
| ratio_sel | input | 1 | Boost ratio: 0 gives 2, 1 gives 4 |
| sample_strobe | output | 1 | One-cycle pulse at each sampling instant |
| filter_tick | output | 1 | One-cycle pulse at each inner-oscillator expiry |

## Verification
The hardest situation to reach from the ports is a change of mode or correction that lands in the middle of a running interval. Applied carelessly, it just looks like a new setting. The stimulus first waits for a strobe, then counts edges and alters `correction` or `fast_mode` a fixed number of cycles into the interval. It measures that interval and the one after it, so any early capture shows up as a wrong length or a wrong tick count. The two saturation limits are reached with extreme nominal and correction words, including one full 65535-cycle interval.

// File: rtl/sdco_pkg.sv
package sdco_pkg;

    localparam int PERIOD_W   = 16;
    localparam int CORR_W     = 16;
    localparam int DIFF_W     = PERIOD_W + 2;
    localparam int MIN_PERIOD = 2;
    localparam int DIV_W      = 2;

    typedef logic [PERIOD_W-1:0]        period_t;
    typedef logic signed [CORR_W-1:0]   corr_t;
    typedef logic [DIV_W-1:0]           div_t;

    typedef enum logic [1:0] {
        RATE_NORMAL = 2'd0,
        RATE_X2     = 2'd1,
        RATE_X4     = 2'd2
    } rate_e;

    typedef struct packed {
        rate_e   rate;
        period_t load;
    } reload_t;

    localparam period_t MAX_PERIOD_V = {PERIOD_W{1'b1}};
    localparam period_t MIN_PERIOD_V = period_t'(MIN_PERIOD);

    // Saturated corrected period: t0 - c clamped to the legal range.
    function automatic period_t sat_period(input period_t t0, input corr_t c);
        logic signed [DIFF_W-1:0] d;
        d = $signed({2'b00, t0}) - $signed({{(DIFF_W-CORR_W){c[CORR_W-1]}}, c});
        if (d < $signed(DIFF_W'(MIN_PERIOD)))
            return MIN_PERIOD_V;
        else if (d > $signed({2'b00, MAX_PERIOD_V}))
            return MAX_PERIOD_V;
        else
            return d[PERIOD_W-1:0];
    endfunction

    // Period of one inner interval for the chosen rate.
    function automatic period_t inner_period(input period_t p, input rate_e r);
        period_t q;
        case (r)
            RATE_X2: q = p >> 1;
            RATE_X4: q = p >> 2;
            default: q = p;
        endcase
        return (q < MIN_PERIOD_V) ? MIN_PERIOD_V : q;
    endfunction

    // Index of the last inner tick in one outer interval.
    function automatic div_t last_index(input rate_e r);
        case (r)
            RATE_X2: return div_t'(1);
            RATE_X4: return div_t'(3);
            default: return div_t'(0);
        endcase
    endfunction

    function automatic rate_e decode_rate(input logic fast, input logic ratio);
        if (!fast)
            return RATE_NORMAL;
        return ratio ? RATE_X4 : RATE_X2;
    endfunction

endpackage

// File: rtl/sdco_period_calc.sv
module sdco_period_calc
    import sdco_pkg::*;
(
    input  period_t t0,
    input  corr_t   corr,
    input  rate_e   rate_next,
    output reload_t reload
);
    period_t full;

    always_comb begin
        full        = sat_period(t0, corr);
        reload.rate = rate_next;
        reload.load = inner_period(full, rate_next);
    end

    always_comb begin
        assert (reload.load >= MIN_PERIOD_V || $isunknown(t0) || $isunknown(corr))
            else $error("reload below floor");
    end
endmodule

// File: rtl/sdco_interval_counter.sv
module sdco_interval_counter
    import sdco_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  period_t reset_val,
    input  period_t load_val,
    output logic    tick
);
    period_t count_q;

    assign tick = (count_q == period_t'(1));

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= reset_val;
        else if (tick)
            count_q <= load_val;
        else
            count_q <= count_q - period_t'(1);
    end

    // R2: between expiries the counter steps down by exactly one
    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !$isunknown(count_q)) |=> (count_q == $past(count_q) - period_t'(1)));

    // R4: an expiry reloads a value inside the saturated range
    assert_reload_range_R4: assert property (@(posedge clk) disable iff (rst)
        tick |=> (count_q >= MIN_PERIOD_V));

    // R1: the counter never reaches zero
    assert_never_zero_R1: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(count_q) |-> (count_q != '0));
endmodule

// File: rtl/sdco_ratio_prescaler.sv
module sdco_ratio_prescaler
    import sdco_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  fast_in,
    input  logic  ratio_in,
    output rate_e rate_next,
    output logic  strobe
);
    rate_e rate_q;
    div_t  div_q;

    assign strobe    = tick && (div_q == last_index(rate_q));
    assign rate_next = strobe ? decode_rate(fast_in, ratio_in) : rate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= RATE_NORMAL;
            div_q  <= '0;
        end else if (tick) begin
            rate_q <= rate_next;
            div_q  <= strobe ? div_t'(0) : div_q + div_t'(1);
        end
    end

    // R6, R7: inner tick index stays inside the ratio
    assert_div_bound_R7: assert property (@(posedge clk) disable iff (rst)
        div_q <= last_index(rate_q));

    // R9: the rate changes only after a strobe
    assert_rate_at_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> (rate_q == $past(rate_q)));

    // R8: in normal mode every tick is a strobe
    assert_normal_equal_R8: assert property (@(posedge clk) disable iff (rst)
        (rate_q == RATE_NORMAL) |-> (strobe == tick));
endmodule

// File: rtl/sampling_dco.sv
module sampling_dco
    import sdco_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [PERIOD_W-1:0] nominal_period,
    input  logic [CORR_W-1:0]   correction,
    input  logic                fast_mode,
    input  logic                ratio_sel,
    output logic                sample_strobe,
    output logic                filter_tick
);
    rate_e   rate_next;
    reload_t reload;
    period_t reset_val;
    logic    tick;
    logic    strobe;

    assign reset_val = sat_period(nominal_period, corr_t'(0));

    sdco_period_calc u_calc (
        .t0        (nominal_period),
        .corr      (corr_t'(correction)),
        .rate_next (rate_next),
        .reload    (reload)
    );

    sdco_interval_counter u_count (
        .clk       (clk),
        .rst       (rst),
        .reset_val (reset_val),
        .load_val  (reload.load),
        .tick      (tick)
    );

    sdco_ratio_prescaler u_div (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .fast_in   (fast_mode),
        .ratio_in  (ratio_sel),
        .rate_next (rate_next),
        .strobe    (strobe)
    );

    assign sample_strobe = strobe;
    assign filter_tick   = tick;

    // R1: reset leaves both outputs quiet in the following cycle
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!sample_strobe && !filter_tick));

    // R10: the strobe lasts one cycle
    assert_strobe_single_R10: assert property (@(posedge clk) disable iff (rst)
        sample_strobe |=> !sample_strobe);

    // R8: a strobe always coincides with a filter tick
    assert_strobe_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
        sample_strobe |-> filter_tick);
endmodule

// File: tb/sampling_dco_bench.sv
module sampling_dco_bench;

    typedef struct packed {
        logic               fast;
        logic               ratio;
        logic [15:0]        t0;
        logic signed [15:0] c;
        logic [15:0]        outer;
        logic [2:0]         ticks;
        logic [15:0]        inner;
    } vec_t;

    localparam int NVEC = 14;
    // fast, ratio, T0, c, outer interval, ticks per interval, first inner gap
    localparam vec_t VECS [0:NVEC-1] = '{
        '{1'b0, 1'b0, 16'd100,   16'sd0,    16'd100,   3'd1, 16'd100},   // R3
        '{1'b0, 1'b0, 16'd100,   16'sd10,   16'd90,    3'd1, 16'd90},    // R2
        '{1'b0, 1'b0, 16'd100,  -16'sd20,   16'd120,   3'd1, 16'd120},   // R2
        '{1'b0, 1'b0, 16'd50,    16'sd49,   16'd2,     3'd1, 16'd2},     // R4 R10
        '{1'b0, 1'b0, 16'd50,    16'sd200,  16'd2,     3'd1, 16'd2},     // R4 R10
        '{1'b1, 1'b0, 16'd200,   16'sd0,    16'd200,   3'd2, 16'd100},   // R6
        '{1'b1, 1'b0, 16'd200,   16'sd20,   16'd180,   3'd2, 16'd90},    // R6
        '{1'b1, 1'b0, 16'd201,   16'sd0,    16'd200,   3'd2, 16'd100},   // R6
        '{1'b1, 1'b1, 16'd400,   16'sd0,    16'd400,   3'd4, 16'd100},   // R7
        '{1'b1, 1'b1, 16'd403,   16'sd3,    16'd400,   3'd4, 16'd100},   // R7
        '{1'b1, 1'b1, 16'd6,     16'sd0,    16'd8,     3'd4, 16'd2},     // R7 floor
        '{1'b1, 1'b0, 16'd9,     16'sd0,    16'd8,     3'd2, 16'd4},     // R6
        '{1'b0, 1'b0, 16'd30,   -16'sd2,    16'd32,    3'd1, 16'd32},    // R2 R8
        '{1'b0, 1'b0, 16'd65500,-16'sd100,  16'd65535, 3'd1, 16'd65535}  // R4
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] nominal_period = 16'd20;
    logic [15:0] correction = 16'd0;
    logic        fast_mode = 1'b1;
    logic        ratio_sel = 1'b1;
    logic        sample_strobe;
    logic        filter_tick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit tick_mismatch;

    always #5 clk = ~clk;

    sampling_dco u_sampling_dco (
        .clk            (clk),
        .rst            (rst),
        .nominal_period (nominal_period),
        .correction     (correction),
        .fast_mode      (fast_mode),
        .ratio_sel      (ratio_sel),
        .sample_strobe  (sample_strobe),
        .filter_tick    (filter_tick)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Starts in a strobe cycle; counts edges to the next strobe.
    task automatic measure(input int mid_edge, input logic [15:0] mid_c, input logic mid_fast,
                           output int outer, output int ticks, output int first_inner);
        int n;
        n = 0; ticks = 0; first_inner = 0;
        tick_mismatch = 1'b0;
        do begin
            @(posedge clk); #1;
            n++;
            if (filter_tick) begin
                ticks++;
                if (first_inner == 0) first_inner = n;
            end
            if (!fast_mode && !ratio_sel && (filter_tick != sample_strobe) && ticks == 0)
                tick_mismatch = 1'b1;
            if (n == mid_edge) begin
                correction = mid_c;
                fast_mode  = mid_fast;
            end
        end while (!sample_strobe && n < 70000);
        outer = n;
    endtask

    initial begin
        int n, o, t, fi;
        bit quiet;
        // R1: outputs low during reset
        quiet = 1'b1;
        repeat (3) begin
            @(posedge clk); #1;
            if (sample_strobe || filter_tick) quiet = 1'b0;
        end
        check("R1 quiet in reset", int'(quiet), 1);
        rst = 1'b0;
        // R1, R8: first strobe after T0-1 edges, normal mode despite fast pins
        n = 0;
        quiet = 1'b1;
        do begin
            @(posedge clk); #1;
            n++;
            if (n == 1 && (sample_strobe || filter_tick)) quiet = 1'b0;
            if (filter_tick != sample_strobe) quiet = 1'b0;
        end while (!sample_strobe && n < 1000);
        check("R1 first strobe edges", n, 19);
        check("R8 reset starts normal", int'(quiet), 1);
        // R9, R7: fast x4 adopted at that strobe
        measure(0, 16'd0, 1'b1, o, t, fi);
        check("R7 outer after reset", o, 20);
        check("R7 ticks after reset", t, 4);
        check("R7 inner after reset", fi, 5);

        for (int i = 0; i < NVEC; i++) begin
            nominal_period = VECS[i].t0;
            correction     = VECS[i].c;
            fast_mode      = VECS[i].fast;
            ratio_sel      = VECS[i].ratio;
            measure(0, VECS[i].c, VECS[i].fast, o, t, fi);
            check($sformatf("R2/R4/R6/R7 vec %0d outer", i), o, int'(VECS[i].outer));
            check($sformatf("R6/R7/R8 vec %0d ticks", i), t, int'(VECS[i].ticks));
            check($sformatf("R6/R7 vec %0d inner", i), fi, int'(VECS[i].inner));
        end

        // R5: mid-interval correction change
        nominal_period = 16'd100; correction = 16'd0; fast_mode = 1'b0; ratio_sel = 1'b0;
        measure(10, 16'd50, 1'b0, o, t, fi);
        check("R5 running interval kept", o, 100);
        measure(0, 16'd50, 1'b0, o, t, fi);
        check("R5 next interval uses new c", o, 50);

        // R9: mid-interval mode change
        nominal_period = 16'd80; correction = 16'd0;
        measure(10, 16'd0, 1'b1, o, t, fi);
        check("R9 interval kept", o, 80);
        check("R9 ticks kept", t, 1);
        measure(0, 16'd0, 1'b1, o, t, fi);
        check("R9 fast outer", o, 80);
        check("R9 fast ticks", t, 2);
        check("R9 fast inner", fi, 40);

        // R10: no strobe in the cycle following one
        @(posedge clk); #1;
        check("R10 strobe single", int'(sample_strobe), 0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule